// File: doc/BRIEF.md
# Serial Clock Phase Generator

This block turns a fast functional clock into the serial clock of a two-wire bus master. The two phases of the serial clock are set separately. A 32-bit divider word is split into two 16-bit fields. The lower field sets the low phase and the upper field sets the high phase. Each phase lasts eight functional-clock cycles for every count of its field plus one. For a symmetric clock, both fields are given the same value `fclk/(rate*16) - 1`, which gives a period of `16*(value+1)` cycles.

The bus engine that owns start, stop and data sequencing raises `enable` and `active` to run the generator. It takes four single-cycle strobes from the generator: one where the clock falls, one where it rises, one at the middle of the low phase (the point to change data) and one at the middle of the high phase (the point to sample data). While the generator is stopped, the clock line rests high. The divider word is captured only while the generator is stopped, so a word written while the engine is disabled is in force at the next start.

Top module: `scl_phase_gen`

## Requirements
- R1: After reset, and on every cycle while the generator is stopped, `scl_out` is 1 and all four strobes are 0.
- R2: The low phase lasts 8*(L+1) cycles, where L is `div_cfg[15:0]`.
- R3: The high phase lasts 8*(H+1) cycles, where H is `div_cfg[31:16]`; the period is 8*(L+1)+8*(H+1).
- R4: A field value of 0 gives a phase of exactly 8 cycles.
- R5: `fall_stb` is high for exactly the first cycle of each low phase, and `rise_stb` is high for exactly the first cycle of each high phase. At most one of the four strobes is high in any cycle.
- R6: `mid_low_stb` is high in cycle 4*(L+1) of the low phase and `mid_high_stb` is high in cycle 4*(H+1) of the high phase, counting the first cycle of the phase as 0.
- R7: The generator runs only while both `enable` and `active` are 1. If either is 0 when sampled by a clock edge, `scl_out` is 1 in the cycle after that edge.
- R8: `div_cfg` is captured only while the generator is stopped. A change while it runs has no effect on the timing. A value held for at least one stopped cycle governs the next run.
- R9: When a run starts, the first phase is low. It begins in the cycle after the edge that first samples `enable` and `active` both at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Engine enabled |
| active | input | 1 | Bus operation in progress |
| div_cfg | input | 32 | Divider word: [15:0] low phase, [31:16] high phase |
| scl_out | output | 1 | Serial clock level |
| fall_stb | output | 1 | First cycle of a low phase |
| rise_stb | output | 1 | First cycle of a high phase |
| mid_low_stb | output | 1 | Middle of the low phase, data change point |
| mid_high_stb | output | 1 | Middle of the high phase, data sample point |

## Verification
On every cycle, the assertions check that the clock rests high after the run condition drops and that no two strobes coincide. They also check that every falling clock edge carries `fall_stb` and every rise during a run carries `rise_stb`, that edge strobes agree with the clock level, and that the captured divider stays frozen during a run. Phase lengths, the exact cycles of the mid-phase strobes, the zero-divider minimum and the rule that the divider is captured only while stopped depend on counted cycles and on a chosen history of `div_cfg`. Only the bench scenarios show these, by comparing each cycle against an independent period model.

// File: rtl/scl_phase_gen.sv
module scl_phase_gen #(
  parameter int FIELD_W = 16,
  parameter int SCALE_LOG2 = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               active,
  input  logic [2*FIELD_W-1:0] div_cfg,
  output logic               scl_out,
  output logic               fall_stb,
  output logic               rise_stb,
  output logic               mid_low_stb,
  output logic               mid_high_stb
);
  localparam int CW = FIELD_W + SCALE_LOG2;

  logic                 run, running, scl_q;
  logic [2*FIELD_W-1:0] cfg_q;
  logic [CW-1:0]        cnt;
  logic [FIELD_W-1:0]   lo_div, hi_div;
  logic [CW-1:0]        lo_last, hi_last, lo_mid, hi_mid;

  assign run     = enable & active;
  assign lo_div  = cfg_q[FIELD_W-1:0];
  assign hi_div  = cfg_q[2*FIELD_W-1:FIELD_W];
  assign lo_last = {lo_div, {SCALE_LOG2{1'b1}}};
  assign hi_last = {hi_div, {SCALE_LOG2{1'b1}}};
  assign lo_mid  = {1'b0, lo_div, {(SCALE_LOG2-1){1'b1}}};
  assign hi_mid  = {1'b0, hi_div, {(SCALE_LOG2-1){1'b1}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (!run) begin
      cfg_q <= div_cfg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      scl_q   <= 1'b1;
      cnt     <= '0;
    end else if (!run) begin
      running <= 1'b0;
      scl_q   <= 1'b1;
      cnt     <= '0;
    end else if (!running) begin
      running <= 1'b1;
      scl_q   <= 1'b0;
      cnt     <= lo_last;
    end else if (cnt == '0) begin
      scl_q <= ~scl_q;
      cnt   <= scl_q ? lo_last : hi_last;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign scl_out      = scl_q;
  assign fall_stb     = running & ~scl_q & (cnt == lo_last);
  assign rise_stb     = running &  scl_q & (cnt == hi_last);
  assign mid_low_stb  = running & ~scl_q & (cnt == lo_mid);
  assign mid_high_stb = running &  scl_q & (cnt == hi_mid);

  // R7
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(enable && active) |=> scl_out);

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fall_stb, rise_stb, mid_low_stb, mid_high_stb}));

  // R5
  fall_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_out) |-> fall_stb);

  // R5
  rise_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(scl_out) && $past(enable && active)) |-> rise_stb);

  // R5
  edge_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_stb |-> !scl_out) and (rise_stb |-> scl_out));

  // R8
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |-> $stable(cfg_q));
endmodule

// File: tb/scl_phase_gen_tb.sv
`timescale 1ns/1ps
module scl_phase_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        active = 1'b0;
  logic [31:0] div_cfg = '0;
  logic scl_out, fall_stb, rise_stb, mid_low_stb, mid_high_stb;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  scl_phase_gen dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .active(active),
    .div_cfg(div_cfg), .scl_out(scl_out), .fall_stb(fall_stb),
    .rise_stb(rise_stb), .mid_low_stb(mid_low_stb), .mid_high_stb(mid_high_stb)
  );

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {scl,fall,rise,midl,midh} actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {scl_out, fall_stb, rise_stb, mid_low_stb, mid_high_stb};
  endfunction

  function automatic logic [4:0] model(input int i, input int dl, input int dh);
    int ll = 8 * (dl + 1);
    int lh = 8 * (dh + 1);
    int p = i % (ll + lh);
    return {p >= ll, p == 0, p == ll, p == ll / 2, p == ll + lh / 2};
  endfunction

  // Starts a run and compares ncyc cycles to the model; optionally alters div_cfg mid-run.
  task automatic run_cmp(input string tag, input int dl, input int dh, input int ncyc,
                         input logic [31:0] alt_cfg, input bit alter);
    int bad = 0;
    logic [4:0] first_bad_a = '0, first_bad_e = '0;
    @(negedge clk);
    enable = 1'b1; active = 1'b1;
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < ncyc; i++) begin
      if (outs() !== model(i, dl, dh)) begin
        if (bad == 0) begin first_bad_a = outs(); first_bad_e = model(i, dl, dh); end
        bad++;
      end
      if (alter && i == 3) div_cfg = alt_cfg;
      @(negedge clk);
    end
    check(tag, bad == 0 ? 5'b0 : first_bad_a, bad == 0 ? 5'b0 : first_bad_e);
    active = 1'b0;
    @(negedge clk);
    check({tag, " R7 stop"}, outs(), 5'b10000);
    enable = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset", outs(), 5'b10000);
    @(negedge clk);
    check("R1 idle", outs(), 5'b10000);
  endtask

  task automatic t_symmetric();
    div_cfg = {16'd1, 16'd1};
    @(negedge clk);
    run_cmp("R2 R3 R5 R6 R9 symmetric", 1, 1, 96, '0, 1'b0);
  endtask

  task automatic t_zero();
    div_cfg = '0;
    @(negedge clk);
    run_cmp("R4 zero divider", 0, 0, 64, '0, 1'b0);
  endtask

  task automatic t_asym();
    div_cfg = {16'd5, 16'd2};
    @(negedge clk);
    run_cmp("R2 R3 asymmetric", 2, 5, 160, '0, 1'b0);
    div_cfg = {16'd0, 16'd3};
    @(negedge clk);
    run_cmp("R2 R6 low longer", 3, 0, 100, '0, 1'b0);
  endtask

  task automatic t_gate();
    div_cfg = {16'd0, 16'd0};
    @(negedge clk);
    enable = 1'b1; active = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R7 enable only", outs(), 5'b10000);
    end
    enable = 1'b0; active = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R7 active only", outs(), 5'b10000);
    end
    active = 1'b0;
    @(negedge clk);
    enable = 1'b1; active = 1'b1;
    repeat (12) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R7 drop in high phase", outs(), 5'b10000);
    @(negedge clk);
    check("R1 stopped", outs(), 5'b10000);
  endtask

  task automatic t_capture();
    div_cfg = {16'd1, 16'd2};
    @(negedge clk);
    run_cmp("R8 change ignored", 2, 1, 120, {16'd0, 16'd0}, 1'b1);
    @(negedge clk);
    run_cmp("R8 next run uses new", 0, 0, 48, '0, 1'b0);
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_symmetric();
    t_zero();
    t_asym();
    t_gate();
    t_capture();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule